// File: doc/BRIEF.md
# Serial-Output SHA-1 Block Digest Engine

This block computes a 160-bit message authentication code over one 512-bit message block that has already been padded. It uses the SHA-1 compression function. A host writes the sixteen 32-bit message words by index while the engine is idle and then pulses `start`. The engine sets its five working words to the standard initial chaining values and runs eighty rounds, one round per clock. The message schedule is expanded on the fly in a sliding window of sixteen words. After the rounds, the engine adds the initial values back into the working words.

The 160-bit result is then sent out one bit per clock on `bit_out`, with `bit_valid` high for each bit. The stream begins with bit 0 of the first working word. A one-cycle `done` pulse follows the last bit. The message window is consumed during the rounds, so all sixteen words must be written again before each new start.

Top module: `sha1_serial_mac`

## Requirements
- R1: While `busy` is low, a cycle with `ld_en` high stores `ld_word` as message word number `ld_idx` (0 to 15, where word 0 is the first schedule word). All sixteen words must be written before each start.
- R2: A `start` pulse seen at a clock edge while `busy` is low begins a computation. `busy` is high from that edge through the edge that ends the last output bit, which is 241 edges in total. `busy` then goes low.
- R3: Schedule word t equals message word t for t below 16. For t from 16 to 79 it is the XOR of words t-3, t-8, t-14 and t-16, rotated left by one bit.
- R4: Each round computes ROTL5(A) + f + E + W + K modulo 2^32 and moves the words along: E takes D, D takes C, C takes ROTL30(B), B takes A, and A takes the sum. Rounds 0-19 use choose(B,C,D) with 5A827999h. Rounds 20-39 use parity with 6ED9EBA1h. Rounds 40-59 use majority with 8F1BBCDCh. Rounds 60-79 use parity with CA62C1D6h.
- R5: The working words start at 67452301h, EFCDAB89h, 98BADCFEh, 10325476h and C3D2E1F0h. The same five values are added back modulo 2^32 after round 79, so the result equals the SHA-1 digest of the block.
- R6: `bit_valid` is high for exactly 160 consecutive cycles, starting 81 edges after the start edge. The bits come out in this order: A bit 0 through bit 31, then B, C, D and E in the same way. `bit_out` is 0 whenever `bit_valid` is low.
- R7: `done` is high for one cycle only, in the cycle right after the last valid bit. `busy` is already low in that cycle.
- R8: A `start` that arrives while `busy` is high is ignored. The timing and the result of the current run do not change.
- R9: An `ld_en` that arrives while `busy` is high is ignored. The digest of the current run does not change.
- R10: After reset, `busy`, `bit_valid`, `bit_out` and `done` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_en | input | 1 | Write strobe for a message word |
| ld_idx | input | 4 | Index of the message word to write (0-15) |
| ld_word | input | 32 | Value of the message word |
| start | input | 1 | Begins a computation when idle |
| busy | output | 1 | High while rounds or readout are in progress |
| bit_out | output | 1 | Serial digest bit |
| bit_valid | output | 1 | `bit_out` holds a digest bit |
| done | output | 1 | One-cycle pulse after the final bit |

## Verification
The assertions check the control structure on every cycle. They check that the phases are mutually exclusive and that the round counter advances by one on every cycle even while a start is pending (R8). They also check that a valid bit never appears without `busy`, that loads and schedule shifts never coincide, and that `done` is a single-cycle pulse that directly follows a valid bit (R7). The numerical results can only be shown by the bench scenarios: schedule expansion, the round functions and constants, the final addition, and the bit order of the stream (R3 to R6). The bench recomputes the digest of several blocks with its own model and compares every output against it on every clock. Those scenarios include start and load strobes injected during the rounds and during readout.

// File: rtl/sha1_mac_pkg.sv
package sha1_mac_pkg;
  localparam int WORD_W   = 32;
  localparam int NUM_MSG  = 16;
  localparam int NUM_RND  = 80;
  localparam int NUM_REG  = 5;
  localparam int OUT_BITS = WORD_W * NUM_REG;
  localparam int IDX_W    = $clog2(NUM_MSG);
  localparam int RND_W    = $clog2(NUM_RND);
  localparam int CNT_W    = $clog2(OUT_BITS);

  typedef logic [WORD_W-1:0] word_t;
  typedef enum logic [1:0] {PH_IDLE, PH_RUN, PH_FIN, PH_OUT} phase_t;

  localparam word_t IV_A = 32'h67452301;
  localparam word_t IV_B = 32'hEFCDAB89;
  localparam word_t IV_C = 32'h98BADCFE;
  localparam word_t IV_D = 32'h10325476;
  localparam word_t IV_E = 32'hC3D2E1F0;

  function automatic word_t rotl(input word_t x, input int n);
    return (x << n) | (x >> (WORD_W - n));
  endfunction

  function automatic word_t mix_fn(input logic [RND_W-1:0] t,
                                   input word_t b, input word_t c, input word_t d);
    if (t < 7'd20)      return (b & c) | (~b & d);
    else if (t < 7'd40) return b ^ c ^ d;
    else if (t < 7'd60) return (b & c) | (b & d) | (c & d);
    else                return b ^ c ^ d;
  endfunction

  function automatic word_t rnd_const(input logic [RND_W-1:0] t);
    if (t < 7'd20)      return 32'h5A827999;
    else if (t < 7'd40) return 32'h6ED9EBA1;
    else if (t < 7'd60) return 32'h8F1BBCDC;
    else                return 32'hCA62C1D6;
  endfunction
endpackage

// File: rtl/sha1_msg_window.sv
module sha1_msg_window
  import sha1_mac_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  word_t            wr_data,
  input  logic             slide_en,
  output word_t            w_now
);
  word_t slot [NUM_MSG];
  word_t w_next;

  // R3: new word t+16 from words t+13, t+8, t+2 and t
  assign w_next = rotl(slot[NUM_MSG-3] ^ slot[NUM_MSG-8] ^ slot[2] ^ slot[0], 1);
  assign w_now  = slot[0];

  for (genvar i = 0; i < NUM_MSG; i++) begin : g_slot
    if (i < NUM_MSG - 1) begin : g_mid
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                   slot[i] <= '0;
        else if (wr_en && wr_idx == IDX_W'(i))        slot[i] <= wr_data;
        else if (slide_en)                            slot[i] <= slot[i+1];
      end
    end else begin : g_last
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                   slot[i] <= '0;
        else if (wr_en && wr_idx == IDX_W'(i))        slot[i] <= wr_data;
        else if (slide_en)                            slot[i] <= w_next;
      end
    end
  end

  // R9
  load_vs_slide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && slide_en));
endmodule

// File: rtl/sha1_work_regs.sv
module sha1_work_regs
  import sha1_mac_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seed_en,
  input  logic             round_en,
  input  logic [RND_W-1:0] round_t,
  input  word_t            w_in,
  input  logic             final_en,
  input  logic             shift_en,
  output logic             lsb_out
);
  word_t ra, rb, rc, rd, re;
  word_t round_sum;
  logic [OUT_BITS-1:0] chain, chain_sh;

  // R4
  assign round_sum = rotl(ra, 5) + mix_fn(round_t, rb, rc, rd) + re + w_in + rnd_const(round_t);
  // R6: A occupies the low end so its bit 0 leaves first
  assign chain    = {re, rd, rc, rb, ra};
  assign chain_sh = chain >> 1;
  assign lsb_out  = ra[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ra <= '0; rb <= '0; rc <= '0; rd <= '0; re <= '0;
    end else if (seed_en) begin
      // R5
      ra <= IV_A; rb <= IV_B; rc <= IV_C; rd <= IV_D; re <= IV_E;
    end else if (round_en) begin
      ra <= round_sum;
      rb <= ra;
      rc <= rotl(rb, 30);
      rd <= rc;
      re <= rd;
    end else if (final_en) begin
      ra <= ra + IV_A; rb <= rb + IV_B; rc <= rc + IV_C;
      rd <= rd + IV_D; re <= re + IV_E;
    end else if (shift_en) begin
      {re, rd, rc, rb, ra} <= chain_sh;
    end
  end

  // R4
  one_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({seed_en, round_en, final_en, shift_en}));
endmodule

// File: rtl/sha1_seq_ctrl.sv
module sha1_seq_ctrl
  import sha1_mac_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             seed_en,
  output logic             round_en,
  output logic [RND_W-1:0] round_t,
  output logic             final_en,
  output logic             shift_en,
  output logic             busy,
  output logic             done
);
  phase_t           phase;
  logic [CNT_W-1:0] cnt;
  logic             last_round, last_bit;

  assign last_round = (cnt == CNT_W'(NUM_RND - 1));
  assign last_bit   = (cnt == CNT_W'(OUT_BITS - 1));
  assign seed_en    = (phase == PH_IDLE) && start;
  assign round_en   = (phase == PH_RUN);
  assign final_en   = (phase == PH_FIN);
  assign shift_en   = (phase == PH_OUT);
  assign round_t    = cnt[RND_W-1:0];
  assign busy       = (phase != PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: if (start) begin phase <= PH_RUN; cnt <= '0; end
        PH_RUN: begin
          if (last_round) begin phase <= PH_FIN; cnt <= '0; end
          else cnt <= cnt + 1'b1;
        end
        PH_FIN: begin phase <= PH_OUT; cnt <= '0; end
        PH_OUT: begin
          if (last_bit) begin phase <= PH_IDLE; cnt <= '0; done <= 1'b1; end
          else cnt <= cnt + 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R8
  round_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (round_en && !last_round) |=> (round_en && cnt == $past(cnt) + 1'b1));
  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7
  done_after_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(shift_en) && !busy));
  // R2
  round_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    round_en |-> (cnt < CNT_W'(NUM_RND)));
endmodule

// File: rtl/sha1_serial_mac.sv
module sha1_serial_mac
  import sha1_mac_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ld_en,
  input  logic [3:0]  ld_idx,
  input  logic [31:0] ld_word,
  input  logic        start,
  output logic        busy,
  output logic        bit_out,
  output logic        bit_valid,
  output logic        done
);
  logic             seed_en, round_en, final_en, shift_en, lsb, win_we;
  logic [RND_W-1:0] round_t;
  word_t            w_cur;

  // R1, R9: loads only while idle
  assign win_we    = ld_en && !busy;
  assign bit_valid = shift_en;
  assign bit_out   = shift_en & lsb;

  sha1_seq_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .seed_en(seed_en), .round_en(round_en), .round_t(round_t),
    .final_en(final_en), .shift_en(shift_en), .busy(busy), .done(done)
  );

  sha1_msg_window i_win (
    .clk(clk), .rst_n(rst_n), .wr_en(win_we), .wr_idx(ld_idx),
    .wr_data(ld_word), .slide_en(round_en), .w_now(w_cur)
  );

  sha1_work_regs i_regs (
    .clk(clk), .rst_n(rst_n), .seed_en(seed_en), .round_en(round_en),
    .round_t(round_t), .w_in(w_cur), .final_en(final_en),
    .shift_en(shift_en), .lsb_out(lsb)
  );

  // R6
  valid_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |-> busy);
  // R6
  quiet_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |-> !bit_out);
endmodule

// File: tb/test_sha1_serial_mac.sv
module test_sha1_serial_mac;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_en = 1'b0;
  logic [3:0]  ld_idx = '0;
  logic [31:0] ld_word = '0;
  logic        start = 1'b0;
  logic        busy, bit_out, bit_valid, done;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] msg [16];
  logic [31:0] ref_h [5];

  always #4 clk = ~clk;  // 125 MHz

  sha1_serial_mac i_sha1_serial_mac (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_idx(ld_idx), .ld_word(ld_word),
    .start(start), .busy(busy), .bit_out(bit_out), .bit_valid(bit_valid), .done(done)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rl(input logic [31:0] x, input int k);
    logic [63:0] d;
    d = {x, x} << k;
    return d[63:32];
  endfunction

  // Reference model of R3, R4, R5: whole schedule held as 80 integers
  task automatic ref_digest();
    logic [31:0] w [80];
    logic [31:0] a, b, c, d, e, f, k, s;
    logic [31:0] iv [5];
    iv[0] = 32'h67452301; iv[1] = 32'hEFCDAB89; iv[2] = 32'h98BADCFE;
    iv[3] = 32'h10325476; iv[4] = 32'hC3D2E1F0;
    for (int t = 0; t < 80; t++)
      w[t] = (t < 16) ? msg[t] : rl(w[t-3] ^ w[t-8] ^ w[t-14] ^ w[t-16], 1);
    a = iv[0]; b = iv[1]; c = iv[2]; d = iv[3]; e = iv[4];
    for (int t = 0; t < 80; t++) begin
      case (t / 20)
        0: begin f = d ^ (b & (c ^ d));          k = 32'h5A827999; end
        1: begin f = b ^ c ^ d;                  k = 32'h6ED9EBA1; end
        2: begin f = (b & c) | (d & (b | c));    k = 32'h8F1BBCDC; end
        default: begin f = b ^ c ^ d;            k = 32'hCA62C1D6; end
      endcase
      s = rl(a, 5) + f + e + w[t] + k;
      e = d; d = c; c = rl(b, 30); b = a; a = s;
    end
    ref_h[0] = a + iv[0]; ref_h[1] = b + iv[1]; ref_h[2] = c + iv[2];
    ref_h[3] = d + iv[3]; ref_h[4] = e + iv[4];
  endtask

  task automatic load_block();  // R1
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_idx = 4'(i); ld_word = msg[i];
    end
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  // Runs one block and compares all outputs on every clock against the model.
  task automatic run_block(input bit inject);
    int idx;
    logic eb, ev, ebit, ed;
    ref_digest();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int n = 0; n < 244; n++) begin
      eb   = (n <= 240);
      ev   = (n >= 81) && (n <= 240);
      idx  = n - 81;
      ebit = ev ? ref_h[idx / 32][idx % 32] : 1'b0;
      ed   = (n == 241);
      chk(busy == eb, "R2 busy", int'(busy), int'(eb));
      chk(bit_valid == ev, "R6 bit_valid", int'(bit_valid), int'(ev));
      chk(bit_out == ebit, "R5 R6 R8 R9 bit_out", int'(bit_out), int'(ebit));
      chk(done == ed, "R7 done", int'(done), int'(ed));
      // R8, R9: strobes while busy must change nothing
      start = inject && (n == 30 || n == 150);
      ld_en = inject && (n == 10 || n == 120);
      ld_idx = 4'd3; ld_word = 32'hDEADBEEF;
      @(negedge clk);
    end
    start = 1'b0; ld_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    repeat (3) @(negedge clk);
    // R10
    chk(!busy && !bit_valid && !bit_out && !done, "R10 reset outputs",
        int'({busy, bit_valid, bit_out, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done, "R10 after release", int'({busy, done}), 0);

    // Block 1: padded three-byte message; model cross-checked with known digest
    for (int i = 0; i < 16; i++) msg[i] = '0;
    msg[0] = 32'h61626380; msg[15] = 32'h00000018;
    ref_digest();
    chk(ref_h[0] == 32'hA9993E36 && ref_h[4] == 32'h9CD0D89D, "R5 model digest",
        int'(ref_h[0]), int'(32'hA9993E36));
    load_block();
    run_block(1'b0);

    // Block 2: empty message padding, with start and load injected while busy
    for (int i = 0; i < 16; i++) msg[i] = '0;
    msg[0] = 32'h80000000;
    load_block();
    run_block(1'b1);

    // Block 3: pseudo-random words in every index, with injections
    lf = 32'h1234ABCD;
    for (int i = 0; i < 16; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]} ^ (lf * 32'd2654435761);
      msg[i] = lf;
    end
    load_block();
    run_block(1'b1);

    // Block 4: all ones, exercises carries in every addition
    for (int i = 0; i < 16; i++) msg[i] = 32'hFFFFFFFF;
    load_block();
    run_block(1'b0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule